// File: doc/BRIEF.md
# Multiplexed Address/Data Port Sequencer

This block decides what an 8-bit pin group does in every cycle. With bus mode deselected, the pins are open-drain general-purpose I/O. Each pin follows its own general-purpose latch bit: a 0 pulls the pin low, and a 1 releases it. With bus mode selected, the pins carry external memory traffic. A two-bit interface mode then chooses the source. In non-page mode the address byte and the data are time-multiplexed under the address-latch-enable phase. In page mode 1 the pins carry data only. In page mode 2 they carry the low address byte only.

In bus mode the pins are never left to pull-ups. A new value is driven hard for a window of `HARD_CYC` clocks, which gives the longest setup time. A weak keeper then holds that level. The keeper also holds the level through a read phase, until an external device overrides it. While a read phase is open, the block samples the pins. When the phase closes, it presents the last sample together with a one-cycle valid strobe.

Top module: `adport_seq`

## Requirements
- R1: With `bus_en`=0, `pad_oe[i]` = NOT `gp_latch[i]`, `pad_out` is 0 and `keep_en` is 0, whatever the other inputs are.
- R2: With `bus_en`=1, `mif_mode`=2'b00 (non-page) and `ale`=1, the driven source is `addr_lo`, so `pad_out` equals `addr_lo`.
- R3: In non-page mode with `ale`=0 and `wr_dir`=1 (write), `pad_out` equals `wr_data`.
- R4: In non-page mode with `ale`=0 and `wr_dir`=0 (read), the pins are released (`pad_oe`=0), `keep_en`=1, and `pad_out` keeps the last value that was driven in bus mode (0 after reset).
- R5: With `mif_mode`=2'b01 (page mode 1), `ale` has no effect: `wr_dir`=1 drives `wr_data`, `wr_dir`=0 is a read phase, and the address byte never appears.
- R6: With `mif_mode`=2'b10 (page mode 2), `pad_out` always equals `addr_lo`, and neither `ale` nor `wr_dir` has any effect.
- R7: In bus mode, `pad_oe` is all ones for exactly `HARD_CYC` consecutive cycles. The window starts in the cycle in which driving begins, or in which the driven value or its source (address or data) changes. When the window ends, `pad_oe` is all zeros.
- R8: In bus mode, `keep_en` is 1 exactly when `pad_oe` is all zeros. No pin is ever hard-driven and kept in the same cycle.
- R9: In bus mode, a read phase samples `pad_in` on every clock edge. In the cycle after the last edge of a read phase, `rd_valid` is high for one cycle and `rd_data` shows the sample from that last edge. After reset, `rd_data` and `rd_valid` are 0.
- R10: `mif_mode`=2'b11 behaves exactly as non-page mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | 1: memory bus use, 0: general-purpose I/O |
| mif_mode | input | 2 | 00 non-page, 01 page mode 1, 10 page mode 2, 11 as non-page |
| ale | input | 1 | Address-latch-enable phase (non-page mode only) |
| wr_dir | input | 1 | 1 write, 0 read |
| addr_lo | input | 8 | Low address byte |
| wr_data | input | 8 | Write data |
| gp_latch | input | 8 | General-purpose port latch value |
| pad_in | input | 8 | Pin levels as seen at the pads |
| pad_out | output | 8 | Value presented to the pad drivers and keeper |
| pad_oe | output | 8 | Per-pin hard-drive enable |
| keep_en | output | 1 | Weak keeper enable |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-cycle strobe when a read phase closes |

## Verification
The bench builds the block with `HARD_CYC`=3 rather than the default of 2. With a window that long, a value change can land in the middle of a window, and the restart becomes visible. A window can also expire on its own before the keeper takes over. Long runs with a steady page-mode-2 address and sparse random changes of value, source and mode push the timer through both full expiry and interrupted windows. Short read phases that end after one cycle exercise the capture strobe.

// File: rtl/adport_pkg.sv
package adport_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ADDR = 2'd1,
        SRC_DATA = 2'd2,
        SRC_READ = 2'd3
    } src_e;

    localparam logic [1:0] MIF_NONPAGE = 2'b00;
    localparam logic [1:0] MIF_PAGE1   = 2'b01;
    localparam logic [1:0] MIF_PAGE2   = 2'b10;

endpackage

// File: rtl/adport_srcsel.sv
module adport_srcsel
    import adport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         bus_en,
    input  logic [1:0]   mif_mode,
    input  logic         ale,
    input  logic         wr_dir,
    input  logic [W-1:0] addr_lo,
    input  logic [W-1:0] wr_data,
    output src_e         src,
    output logic         drv_req,
    output logic [W-1:0] drv_val
);

    always_comb begin
        src = SRC_NONE;
        if (bus_en) begin
            unique case (mif_mode)
                MIF_PAGE2: src = SRC_ADDR;
                MIF_PAGE1: src = wr_dir ? SRC_DATA : SRC_READ;
                default:   src = ale ? SRC_ADDR : (wr_dir ? SRC_DATA : SRC_READ);
            endcase
        end
        drv_req = (src == SRC_ADDR) || (src == SRC_DATA);
        drv_val = (src == SRC_ADDR) ? addr_lo : wr_data;
    end

endmodule

// File: rtl/adport_hard_timer.sv
module adport_hard_timer
    import adport_pkg::*;
#(
    parameter int W        = 8,
    parameter int HARD_CYC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drv_req,
    input  src_e         src,
    input  logic [W-1:0] drv_val,
    output logic         hard,
    output logic [W-1:0] hold_val
);

    localparam int CW = $clog2(HARD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  val;
        src_e          src;
        logic          drv;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic restart;

    always_comb begin
        tmr_d    = tmr_q;
        restart  = drv_req && (!tmr_q.drv || drv_val != tmr_q.val || src != tmr_q.src);
        hard     = drv_req && (restart || tmr_q.cnt != '0);
        hold_val = drv_req ? drv_val : tmr_q.val;
        tmr_d.drv = drv_req;
        if (drv_req) begin
            tmr_d.val = drv_val;
            tmr_d.src = src;
        end
        if (!drv_req)
            tmr_d.cnt = '0;
        else if (restart)
            tmr_d.cnt = CW'(HARD_CYC - 1);
        else if (tmr_q.cnt != '0)
            tmr_d.cnt = tmr_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tmr_q <= '{cnt: '0, val: '0, src: SRC_NONE, drv: 1'b0};
        else
            tmr_q <= tmr_d;
    end

    // R7
    hard_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_req |-> !hard);

    // R7
    hard_window_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hard && !restart) |-> ($stable(drv_val) && $past(drv_req)));

    // R7
    hard_after_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_req && $past(drv_req) && drv_val != $past(drv_val)) |-> hard);

endmodule

// File: rtl/adport_rdcap.sv
module adport_rdcap #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_act,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] rd_data,
    output logic         rd_valid
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         valid;
        logic         act;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.act   = rd_act;
        cap_d.valid = cap_q.act && !rd_act;
        if (rd_act)
            cap_d.data = pad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_q <= '0;
        else
            cap_q <= cap_d;
    end

    assign rd_data  = cap_q.data;
    assign rd_valid = cap_q.valid;

    // R9
    rd_strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!$past(rd_act) && $past(rd_act, 2)));

    // R9
    rd_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/adport_seq.sv
module adport_seq
    import adport_pkg::*;
#(
    parameter int W        = 8,
    parameter int HARD_CYC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_en,
    input  logic [1:0]   mif_mode,
    input  logic         ale,
    input  logic         wr_dir,
    input  logic [W-1:0] addr_lo,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] gp_latch,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic         keep_en,
    output logic [W-1:0] rd_data,
    output logic         rd_valid
);

    src_e         src;
    logic         drv_req;
    logic [W-1:0] drv_val;
    logic         hard;
    logic [W-1:0] hold_val;
    logic         rd_act;

    adport_srcsel #(.W(W)) srcsel_i (
        .bus_en   (bus_en),
        .mif_mode (mif_mode),
        .ale      (ale),
        .wr_dir   (wr_dir),
        .addr_lo  (addr_lo),
        .wr_data  (wr_data),
        .src      (src),
        .drv_req  (drv_req),
        .drv_val  (drv_val)
    );

    adport_hard_timer #(.W(W), .HARD_CYC(HARD_CYC)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .drv_req  (drv_req),
        .src      (src),
        .drv_val  (drv_val),
        .hard     (hard),
        .hold_val (hold_val)
    );

    assign rd_act = bus_en && (src == SRC_READ);

    adport_rdcap #(.W(W)) rdcap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_act   (rd_act),
        .pad_in   (pad_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    always_comb begin
        if (bus_en) begin
            pad_out = hold_val;
            pad_oe  = {W{hard}};
            keep_en = !hard;
        end else begin
            pad_out = '0;
            pad_oe  = ~gp_latch;
            keep_en = 1'b0;
        end
    end

    // R1
    gpio_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (!keep_en && pad_out == '0 && pad_oe == ~gp_latch));

    // R6
    page2_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && mif_mode == MIF_PAGE2) |-> pad_out == addr_lo);

    // R8
    keep_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> ((keep_en && pad_oe == '0) || (!keep_en && pad_oe == '1)));

    // R4
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |-> (pad_oe == '0 && keep_en));

endmodule

// File: tb/adport_seq_tb_top.sv
module adport_seq_tb_top;

    localparam int CLK_P = 10;
    localparam int HC    = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic [1:0] mif_mode = 2'b00;
    logic       ale = 1'b0;
    logic       wr_dir = 1'b0;
    logic [7:0] addr_lo = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] gp_latch = 8'hFF;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe, rd_data;
    logic       keep_en, rd_valid;

    int n_cmp = 0;
    int n_err = 0;

    int         m_cnt = 0;
    bit         m_drv_prev = 0;
    logic [7:0] m_val = 8'h00;
    int         m_src = 0;
    bit         m_rd_prev = 0;
    logic [7:0] m_rd_data = 8'h00;
    bit         m_rd_valid = 0;

    always #(CLK_P / 2) clk = ~clk;

    adport_seq #(.W(8), .HARD_CYC(HC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .mif_mode(mif_mode),
        .ale(ale), .wr_dir(wr_dir), .addr_lo(addr_lo), .wr_data(wr_data),
        .gp_latch(gp_latch), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .keep_en(keep_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int src_of();
        if (!bus_en) return 0;
        if (mif_mode == 2'b10) return 1;
        if (mif_mode == 2'b01) return wr_dir ? 2 : 3;
        return ale ? 1 : (wr_dir ? 2 : 3);
    endfunction

    function automatic string tag_of();
        if (!bus_en) return "R1";
        if (mif_mode == 2'b10) return "R6";
        if (mif_mode == 2'b01) return "R5";
        if (mif_mode == 2'b11) return "R10";
        if (ale) return "R2";
        return wr_dir ? "R3" : "R4";
    endfunction

    task automatic cyc(bit b, logic [1:0] m, bit a, bit d, logic [7:0] ad,
                       logic [7:0] wd, logic [7:0] gp, logic [7:0] pin);
        int         s;
        bit         drv, rs, hard, rd;
        logic [7:0] val;
        @(negedge clk);
        bus_en = b; mif_mode = m; ale = a; wr_dir = d;
        addr_lo = ad; wr_data = wd; gp_latch = gp; pad_in = pin;
        #1;
        s    = src_of();
        drv  = (s == 1) || (s == 2);
        val  = (s == 1) ? addr_lo : wr_data;
        rs   = drv && (!m_drv_prev || val != m_val || s != m_src);
        hard = drv && (rs || m_cnt > 0);
        rd   = (s == 3);
        if (!bus_en) begin
            chk("R1", "pad_oe", pad_oe, ~gp_latch);
            chk("R1", "pad_out", pad_out, 8'h00);
            chk("R1", "keep_en", {7'd0, keep_en}, 8'h00);
        end else begin
            chk(tag_of(), "pad_out", pad_out, drv ? val : m_val);
            chk("R7", "pad_oe", pad_oe, hard ? 8'hFF : 8'h00);
            chk("R8", "keep_en", {7'd0, keep_en}, {7'd0, !hard});
        end
        chk("R9", "rd_data", rd_data, m_rd_data);
        chk("R9", "rd_valid", {7'd0, rd_valid}, {7'd0, m_rd_valid});
        @(posedge clk);
        if (drv) begin
            m_val = val;
            m_src = s;
        end
        if (!drv)       m_cnt = 0;
        else if (rs)    m_cnt = HC - 1;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        m_drv_prev = drv;
        if (rd) m_rd_data = pad_in;
        m_rd_valid = m_rd_prev && !rd;
        m_rd_prev  = rd;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        // reset state
        repeat (2) @(negedge clk);
        #1;
        chk("R1", "reset pad_oe", pad_oe, 8'h00);
        chk("R9", "reset rd_data", rd_data, 8'h00);
        chk("R9", "reset rd_valid", {7'd0, rd_valid}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: GPIO, bus inputs must not matter
        cyc(0, 2'b00, 1, 1, 8'h5A, 8'hC3, 8'hA5, 8'h00);
        cyc(0, 2'b10, 0, 0, 8'h11, 8'h22, 8'h0F, 8'hFF);
        // R4: read right after reset holds 0 via keeper
        cyc(1, 2'b00, 0, 0, 8'h00, 8'h00, 8'hFF, 8'h3C);
        // R2/R3/R4 non-page cycles
        for (int k = 0; k < 4; k++) begin
            cyc(1, 2'b00, 1, 0, 8'h40 + 8'(k), 8'h00, 8'hFF, 8'h00);
            cyc(1, 2'b00, 1, 0, 8'h40 + 8'(k), 8'h00, 8'hFF, 8'h00);
            cyc(1, 2'b00, 0, 1, 8'h40 + 8'(k), 8'h90 + 8'(k), 8'hFF, 8'h00);
            cyc(1, 2'b00, 0, 1, 8'h40 + 8'(k), 8'h90 + 8'(k), 8'hFF, 8'h00);
            cyc(1, 2'b00, 1, 0, 8'h50 + 8'(k), 8'h00, 8'hFF, 8'h00);
            cyc(1, 2'b00, 0, 0, 8'h50 + 8'(k), 8'h00, 8'hFF, 8'hE0 + 8'(k));
            cyc(1, 2'b00, 0, 0, 8'h50 + 8'(k), 8'h00, 8'hFF, 8'h70 + 8'(k));
        end
        // R7: page 2 steady address lets the window expire, then a change restarts it
        for (int k = 0; k < 6; k++) cyc(1, 2'b10, k[0], k[1], 8'h33, 8'hEE, 8'h00, 8'h00);
        cyc(1, 2'b10, 0, 1, 8'h34, 8'hEE, 8'h00, 8'h00);
        cyc(1, 2'b10, 0, 1, 8'h35, 8'hEE, 8'h00, 8'h00);
        for (int k = 0; k < 4; k++) cyc(1, 2'b10, 0, 1, 8'h35, 8'hEE, 8'h00, 8'h00);
        // R5: page 1, ale ignored, one-cycle read phases
        for (int k = 0; k < 5; k++) begin
            cyc(1, 2'b01, 1, 1, 8'hAA, 8'h10 + 8'(k), 8'h00, 8'h00);
            cyc(1, 2'b01, 1, 0, 8'hAA, 8'h00, 8'h00, 8'hC0 + 8'(k));
        end
        // R10: mode 3 as non-page
        cyc(1, 2'b11, 1, 0, 8'h77, 8'h00, 8'h00, 8'h00);
        cyc(1, 2'b11, 0, 1, 8'h77, 8'h88, 8'h00, 8'h00);
        cyc(1, 2'b11, 0, 0, 8'h77, 8'h88, 8'h00, 8'h99);
        // R1: back to GPIO mid-phase
        cyc(0, 2'b11, 0, 0, 8'h77, 8'h88, 8'h3C, 8'h00);
        cyc(0, 2'b00, 1, 1, 8'h77, 8'h88, 8'hC3, 8'h00);
        // random traffic with sparse value changes
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[3:0] != 0, r[5:4], r[6], r[7],
                r[10:8] == 0 ? r[23:16] : addr_lo,
                r[13:11] == 0 ? r[31:24] : wr_data,
                r[23:16], r[31:24]);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule